// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block turns the synchronized D+/D- line pair of a low-speed USB link into a stream of received bytes. It runs at eight clock cycles per bit time. Once armed, it hunts for a J-to-K transition inside the sync field and zeroes its bit-phase counter on that edge so that sampling lands mid-bit. It then waits for the double-K that closes sync. From there it NRZI-decodes the line, drops the stuffed bit that follows six consecutive ones, and packs bits into bytes least significant bit first.

Each finished byte appears on a byte output with a one-clock valid strobe. A single-ended zero (both lines low) ends the packet, except at the first bit position of a byte, where a hub may have added a dribble bit. Three further one-clock flags report the end of the packet, a byte count beyond the configured limit, and a sync hunt that did not finish in time. After any of these flags the block goes idle until it is armed again. Token, CRC and endpoint handling belong to logic downstream.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset all outputs are low and the receiver is idle. While idle, line activity produces no output until a one-clock `arm_i` pulse starts a sync hunt.
- R2: Line state is {dp,dm}: J = 01, K = 10, SE0 = 00. The hunt looks for a J-to-K transition. The receiver then samples at mid-bit and needs two consecutive K samples. A J sample before the second K sends it back to hunting. The first data bit follows the second K.
- R3: A data bit is 1 when the sampled D- level equals the previous sample and 0 when it differs. For the first data bit, the previous sample is the final K of sync. Bits are packed LSB first, and each complete byte is presented on `byte_o` with `byte_vld_o` high for exactly one clock.
- R4: Counting the final sync bit as a first 1, the sample that follows six consecutive decoded 1 bits is a stuffed bit. It is discarded, and the ones count restarts.
- R5: An SE0 sample at bit positions 1 to 7 of a byte ends the packet. `pkt_end_o` pulses for one clock, and any partial byte is discarded.
- R6: An SE0 sample at bit position 0 of a byte does not end the packet. It is decoded as a low D- level, like a K.
- R7: At most MAX_BYTES bytes (default 11) are delivered per packet. When one more byte would complete, it is withheld, `ovf_err_o` pulses for one clock, and reception stops without `pkt_end_o`.
- R8: If the receiver has not reached the data phase SYNC_TIMEOUT clocks (default 160) after arming, `sync_err_o` pulses for one clock and the receiver returns to idle.
- R9: The bit-phase counter restarts on every change of line state. Bit lengths that vary by one clock either way around eight are therefore received correctly.
- R10: At most one of `byte_vld_o`, `pkt_end_o`, `ovf_err_o` and `sync_err_o` is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, eight cycles per bit time |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | One-clock pulse that starts a sync hunt from idle |
| dp_i | input | 1 | D+ line level |
| dm_i | input | 1 | D- line level |
| byte_o | output | 8 | Last received byte |
| byte_vld_o | output | 1 | One-clock strobe for `byte_o` |
| pkt_end_o | output | 1 | One-clock end-of-packet flag |
| ovf_err_o | output | 1 | One-clock byte-limit overflow flag |
| sync_err_o | output | 1 | One-clock sync timeout flag |

## Verification
Packets are built in the bench by an independent NRZI encoder with stuffing. Mixed byte values exercise both decode polarities. Runs of 0xFF force stuffed bits, which a receiver with wrong stuffing would shift into the data. A dribble bit before SE0, and an SE0 replacing a K at a byte's first bit, separate the two SE0 positions. A false single-K start, an idle line and an endless J/K toggle separate the sync retry path from the timeout. A twelve-byte packet probes the byte limit, and a 7/9/8-clock jittered bit stream shows that realignment on each line transition works.

// File: rtl/usb_ls_rx_pkg.sv
// Shared types for the low-speed receiver.
// Line state is packed as {dp, dm}; states of the receive sequencer.
package usb_ls_rx_pkg;

    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'b00,
        RX_HUNT = 2'b01,
        RX_CHK  = 2'b10,
        RX_DATA = 2'b11
    } rx_state_e;

endpackage

// File: rtl/usb_ls_line_sync.sv
// Two-flop synchronizer for the D+/D- pair, plus a one-cycle delayed copy
// used for transition and edge detection.
// Assumes: dp/dm are asynchronous to clk; reset value is bus idle (J).
module usb_ls_line_sync
    import usb_ls_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dp_i,
    input  logic  dm_i,
    output line_e line_o,
    output line_e line_d_o
);

    logic [1:0] meta_q;
    logic [1:0] sync_q;
    logic [1:0] hist_q;

    // Synchronize the line pair and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 2'b01;
            sync_q <= 2'b01;
            hist_q <= 2'b01;
        end else begin
            meta_q <= {dp_i, dm_i};
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign line_o   = line_e'(sync_q);
    assign line_d_o = line_e'(hist_q);

endmodule

// File: rtl/usb_ls_bit_timer.sv
// Bit-phase counter. Phase 0 is the cycle a line transition is seen; the
// sample strobe fires at mid-bit (BIT_CYCLES/2) and every BIT_CYCLES after.
// Assumes: trans_i is high for one cycle per change of line state.
module usb_ls_bit_timer #(
    parameter int BIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trans_i,
    output logic strobe_o
);

    localparam int PW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [PW-1:0] MID  = PW'(BIT_CYCLES / 2);
    localparam logic [PW-1:0] LAST = PW'(BIT_CYCLES - 1);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] ph_now;

    // Current phase: restarted by a transition, else the running count.
    always_comb begin
        ph_now   = trans_i ? '0 : ph_q;
        strobe_o = (ph_now == MID);
    end

    // Advance the phase modulo BIT_CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= (ph_now == LAST) ? '0 : ph_now + PW'(1);
        end
    end

    // R9: strobes are never back to back
    assert_strobe_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/usb_ls_nrzi_unstuff.sv
// NRZI decoder with bit unstuffing. On each sample it compares D- with the
// previous sample (equal = 1). After STUFF_LEN ones the next sample is
// dropped. init_i loads the state left by the end of sync (last level K,
// one 1 already counted).
module usb_ls_nrzi_unstuff #(
    parameter int STUFF_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic smp_i,
    input  logic dm_i,
    output logic bit_vld_o,
    output logic bit_o
);

    localparam int OW = $clog2(STUFF_LEN + 1);
    localparam logic [OW-1:0] STUFF_AT = OW'(STUFF_LEN);

    logic [OW-1:0] ones_q;
    logic          prev_q;
    logic          is_stuff;

    // Decode the current sample and mark stuffed positions.
    always_comb begin
        is_stuff  = (ones_q == STUFF_AT);
        bit_o     = (dm_i == prev_q);
        bit_vld_o = smp_i && !is_stuff;
    end

    // Track the previous level and the run of ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            ones_q <= '0;
        end else if (init_i) begin
            prev_q <= 1'b0;
            ones_q <= OW'(1);
        end else if (smp_i) begin
            prev_q <= dm_i;
            if (is_stuff || !bit_o) ones_q <= '0;
            else                    ones_q <= ones_q + OW'(1);
        end
    end

    // R4: the run of ones never passes the stuffing length
    assert_stuff_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= STUFF_AT);

endmodule

// File: rtl/usb_ls_rx.sv
// Low-speed USB packet receiver top. Hunts for the sync edge, confirms the
// double-K, then assembles decoded bits into bytes until SE0, byte-limit
// overflow, or (before data) a sync timeout. Assumes eight clocks per bit
// and a one-clock arm pulse while idle.
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int BIT_CYCLES   = 8,
    parameter int MAX_BYTES    = 11,
    parameter int SYNC_TIMEOUT = 160,
    parameter int STUFF_LEN    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic       dp_i,
    input  logic       dm_i,
    output logic [7:0] byte_o,
    output logic       byte_vld_o,
    output logic       pkt_end_o,
    output logic       ovf_err_o,
    output logic       sync_err_o
);

    localparam int NBW = $clog2(MAX_BYTES + 1);
    localparam int TW  = $clog2(SYNC_TIMEOUT + 1);
    localparam logic [NBW-1:0] NB_LIMIT = NBW'(MAX_BYTES);
    localparam logic [TW-1:0]  TMO_LAST = TW'(SYNC_TIMEOUT - 1);

    line_e      line;
    line_e      line_d;
    logic       trans;
    logic       strobe;
    rx_state_e  state_q;
    logic       kseen_q;
    logic [TW-1:0]  tmo_q;
    logic [2:0]     bitpos_q;
    logic [7:0]     shreg_q;
    logic [NBW-1:0] nbytes_q;
    logic       eop_hit;
    logic       dec_smp;
    logic       dec_init;
    logic       bit_vld;
    logic       bit_val;
    logic [7:0] next_byte;

    usb_ls_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .dp_i     (dp_i),
        .dm_i     (dm_i),
        .line_o   (line),
        .line_d_o (line_d)
    );

    assign trans = (line != line_d);

    usb_ls_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .trans_i  (trans),
        .strobe_o (strobe)
    );

    // Sample qualification: end of packet, decoder sample, decoder load.
    always_comb begin
        eop_hit  = (state_q == RX_DATA) && strobe && (line == LN_SE0) && (bitpos_q != 3'd0);
        dec_smp  = (state_q == RX_DATA) && strobe && !eop_hit;
        dec_init = (state_q == RX_CHK) && strobe && (line == LN_K) && kseen_q;
    end

    usb_ls_nrzi_unstuff #(.STUFF_LEN(STUFF_LEN)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (dec_init),
        .smp_i     (dec_smp),
        .dm_i      (line[0]),
        .bit_vld_o (bit_vld),
        .bit_o     (bit_val)
    );

    assign next_byte = {bit_val, shreg_q[7:1]};

    // Receive sequencer, byte assembly and one-clock output flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RX_IDLE;
            kseen_q    <= 1'b0;
            tmo_q      <= '0;
            bitpos_q   <= '0;
            shreg_q    <= '0;
            nbytes_q   <= '0;
            byte_o     <= '0;
            byte_vld_o <= 1'b0;
            pkt_end_o  <= 1'b0;
            ovf_err_o  <= 1'b0;
            sync_err_o <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            pkt_end_o  <= 1'b0;
            ovf_err_o  <= 1'b0;
            sync_err_o <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (arm_i) begin
                        state_q <= RX_HUNT;
                        tmo_q   <= '0;
                    end
                end
                RX_HUNT, RX_CHK: begin
                    tmo_q <= tmo_q + TW'(1);
                    if (tmo_q == TMO_LAST) begin
                        sync_err_o <= 1'b1;
                        state_q    <= RX_IDLE;
                    end else if (state_q == RX_HUNT) begin
                        if (line_d == LN_J && line == LN_K) begin
                            state_q <= RX_CHK;
                            kseen_q <= 1'b0;
                        end
                    end else if (strobe) begin
                        if (line != LN_K) begin
                            state_q <= RX_HUNT;
                        end else if (kseen_q) begin
                            state_q  <= RX_DATA;
                            bitpos_q <= '0;
                            nbytes_q <= '0;
                        end else begin
                            kseen_q <= 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (eop_hit) begin
                        pkt_end_o <= 1'b1;
                        state_q   <= RX_IDLE;
                    end else if (bit_vld) begin
                        shreg_q  <= next_byte;
                        bitpos_q <= bitpos_q + 3'd1;
                        if (bitpos_q == 3'd7) begin
                            if (nbytes_q == NB_LIMIT) begin
                                ovf_err_o <= 1'b1;
                                state_q   <= RX_IDLE;
                            end else begin
                                byte_o     <= next_byte;
                                byte_vld_o <= 1'b1;
                                nbytes_q   <= nbytes_q + NBW'(1);
                            end
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // R10: output flags are mutually exclusive
    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_vld_o, pkt_end_o, ovf_err_o, sync_err_o}));

    // R3: byte strobe lasts one clock
    assert_vld_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

    // R7: delivered byte count stays within the limit
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nbytes_q <= NB_LIMIT);

    // R8: a sync error leaves the receiver idle
    assert_sync_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |-> (state_q == RX_IDLE));

    // R2: data phase is only entered from the K check on a K sample
    assert_data_after_kk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DATA && $past(state_q) != RX_DATA) |->
            ($past(state_q) == RX_CHK && $past(line) == LN_K));

endmodule

// File: tb/usb_ls_rx_tb.sv
module usb_ls_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB       = 11;
    localparam logic [1:0] LJ = 2'b01;
    localparam logic [1:0] LK = 2'b10;
    localparam logic [1:0] L0 = 2'b00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic dp = 1'b0;
    logic dm = 1'b1;
    logic [7:0] byte_o;
    logic byte_vld, pkt_end, ovf_err, sync_err;

    usb_ls_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm),
        .dp_i       (dp),
        .dm_i       (dm),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld),
        .pkt_end_o  (pkt_end),
        .ovf_err_o  (ovf_err),
        .sync_err_o (sync_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_vld, n_end, n_ovf, n_serr, n_multi;
    logic [7:0] cap [0:15];
    logic [7:0] tx  [0:15];
    int jit_mode = 0;
    int jit_idx = 0;
    bit done = 0;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin
                if (n_vld < 16) cap[n_vld] = byte_o;
                n_vld++;
            end
            if (pkt_end)  n_end++;
            if (ovf_err)  n_ovf++;
            if (sync_err) n_serr++;
            if ((32'(byte_vld) + 32'(pkt_end) + 32'(ovf_err) + 32'(sync_err)) > 1) n_multi++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_vld = 0; n_end = 0; n_ovf = 0; n_serr = 0;
    endtask

    task automatic drive(input logic [1:0] ln);
        int len;
        {dp, dm} = ln;
        if (jit_mode != 0) begin
            len = (jit_idx % 3 == 0) ? 7 : ((jit_idx % 3 == 1) ? 9 : 8);
            jit_idx++;
        end else begin
            len = 8;
        end
        repeat (len) @(negedge clk);
    endtask

    task automatic pulse_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    // Encode sync plus nb bytes from tx[] with NRZI and stuffing, then EOP.
    task automatic send_frame(input int nb, input bit do_arm, input bit dribble,
                              input int se0_bit, input bit junk);
        logic [1:0] cur;
        int ones;
        bit b;
        if (do_arm) pulse_arm();
        cur = LJ;
        repeat (4) drive(LJ);
        if (junk) begin
            drive(LK); drive(LJ); drive(LJ);
        end
        ones = 0;
        for (int i = 0; i < 8 + 8*nb; i++) begin
            b = (i < 8) ? (i == 7) : tx[(i-8)/8][(i-8)%8];
            if (!b) begin
                cur = {cur[0], cur[1]};
                ones = 0;
            end else begin
                ones++;
            end
            if (i >= 8 && (i-8) == se0_bit) drive(L0);
            else drive(cur);
            if (ones == 6) begin
                cur = {cur[0], cur[1]};
                ones = 0;
                drive(cur);
            end
        end
        if (dribble) drive(cur);
        drive(L0); drive(L0); drive(LJ);
        jit_mode = 0;
        repeat (3) drive(LJ);
    endtask

    task automatic expect_frame(input int nb, input string req);
        check(n_vld == nb, req, n_vld, nb);
        for (int i = 0; i < nb && i < 16; i++)
            check(cap[i] == tx[i], req, int'(cap[i]), int'(tx[i]));
        check(n_end == 1, req, n_end, 1);
        check(n_ovf == 0 && n_serr == 0, req, n_ovf + n_serr, 0);
    endtask

    task automatic test_reset();
        check(byte_vld == 0 && pkt_end == 0, "R1 reset flags", 32'(byte_vld) + 32'(pkt_end), 0);
        check(ovf_err == 0 && sync_err == 0, "R1 reset errors", 32'(ovf_err) + 32'(sync_err), 0);
        check(byte_o == 8'h00, "R1 reset byte", int'(byte_o), 0);
    endtask

    task automatic test_basic();
        clr_mon();
        tx[0] = 8'hC3; tx[1] = 8'h00; tx[2] = 8'h5A;
        send_frame(3, 1, 0, -1, 0);
        expect_frame(3, "R3/R5 basic packet");
    endtask

    task automatic test_noarm();
        clr_mon();
        tx[0] = 8'h11;
        send_frame(1, 0, 0, -1, 0);
        check(n_vld == 0 && n_end == 0, "R1 no arm", n_vld + n_end, 0);
    endtask

    task automatic test_stuff();
        clr_mon();
        tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'h7E; tx[3] = 8'h3F;
        send_frame(4, 1, 0, -1, 0);
        expect_frame(4, "R4 stuffing");
    endtask

    task automatic test_dribble();
        clr_mon();
        tx[0] = 8'hA5; tx[1] = 8'h0F;
        send_frame(2, 1, 1, -1, 0);
        expect_frame(2, "R5 dribble bit");
    endtask

    task automatic test_se0_bit0();
        clr_mon();
        tx[0] = 8'h00; tx[1] = 8'h35; tx[2] = 8'h81;
        send_frame(3, 1, 0, 8, 0);
        expect_frame(3, "R6 SE0 at bit 0");
    endtask

    task automatic test_junk();
        clr_mon();
        tx[0] = 8'h12; tx[1] = 8'h34;
        send_frame(2, 1, 0, -1, 1);
        expect_frame(2, "R2 single K retry");
    endtask

    task automatic test_timeout();
        clr_mon();
        pulse_arm();
        repeat (250) @(negedge clk);
        check(n_serr == 1, "R8 idle timeout", n_serr, 1);
        check(n_vld == 0 && n_end == 0, "R8 no data", n_vld + n_end, 0);
    endtask

    task automatic test_nosync();
        clr_mon();
        pulse_arm();
        for (int i = 0; i < 12; i++) begin
            drive(LK); drive(LJ);
        end
        repeat (40) @(negedge clk);
        check(n_serr == 1, "R2/R8 toggling never syncs", n_serr, 1);
        check(n_vld == 0, "R2 no bytes without double K", n_vld, 0);
    endtask

    task automatic test_overflow();
        clr_mon();
        for (int i = 0; i < MAXB + 1; i++) tx[i] = 8'(i*17 + 3);
        send_frame(MAXB + 1, 1, 0, -1, 0);
        check(n_vld == MAXB, "R7 byte limit", n_vld, MAXB);
        for (int i = 0; i < MAXB; i++)
            check(cap[i] == tx[i], "R7 data", int'(cap[i]), int'(tx[i]));
        check(n_ovf == 1, "R7 overflow flag", n_ovf, 1);
        check(n_end == 0, "R7 no packet end", n_end, 0);
    endtask

    task automatic test_jitter();
        clr_mon();
        tx[0] = 8'hE7; tx[1] = 8'h18; tx[2] = 8'hFE;
        jit_mode = 1; jit_idx = 0;
        send_frame(3, 1, 0, -1, 0);
        expect_frame(3, "R9 jittered bits");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        n_multi = 0;
        clr_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_noarm();
        test_stuff();
        test_dribble();
        test_se0_bit0();
        test_junk();
        test_timeout();
        test_nosync();
        test_overflow();
        test_jitter();
        check(n_multi == 0, "R10 exclusive flags", n_multi, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule